// File: doc/BRIEF.md
# Vector Lane Data Mover

This unit rearranges data in 256-bit vectors at the granularity of 128-bit lanes and of 32- or 64-bit elements. It supports six operations. Broadcast fills a vector from a scalar. Insert replaces one half of a vector. Extract returns one half of a vector. Permute builds a result from the four lanes of two source vectors. Masked load merges a vector and zeroes the elements that the mask does not select. Masked store produces write data together with per-byte write enables, so that memory elements the mask does not select are never written.

A request is presented on the input ports with `in_valid` high. Its result appears on the outputs on the next clock edge, together with `out_valid`. All the movement logic is combinational. A single register stage holds the result, and that stage keeps its value while no request arrives. The unit does not access memory and does not perform arithmetic. The store byte enables are meant to drive a memory write port next to the unit.

Top module: `lane_mover`

## Requirements
- R1: After reset, `out_valid`, `result` and `byte_en` are all zero.
- R2: A request accepted with `in_valid` high is reflected on `result`, `byte_en` and `out_valid`=1 exactly one clock later. In a cycle with `in_valid` low, `out_valid` is 0 on the next clock and `result` and `byte_en` keep their values.
- R3: Broadcast (opcode 0) copies the scalar into every element of the result. `size` 0 replicates scalar bits [31:0] eight times. `size` 1 replicates bits [63:0] four times. `size` 2 or 3 replicates all 128 bits twice.
- R4: Insert (opcode 1) returns `src_a` with one half replaced by `scalar`. With `imm[0]`=0 the lower half [127:0] is replaced. With `imm[0]`=1 the upper half [255:128] is replaced. The other half is passed through unchanged.
- R5: Extract (opcode 2) places the lower half of `src_a` (`imm[0]`=0) or its upper half (`imm[0]`=1) in `result[127:0]` and sets `result[255:128]` to zero.
- R6: Permute (opcode 3) fills `result[127:0]` from the lane chosen by `imm[1:0]` and `result[255:128]` from the lane chosen by `imm[5:4]`. Lane code 0 is `src_a[127:0]`, code 1 is `src_a[255:128]`, code 2 is `src_b[127:0]` and code 3 is `src_b[255:128]`.
- R7: In a permute, `imm[3]`=1 forces `result[127:0]` to zero and `imm[7]`=1 forces `result[255:128]` to zero, whatever the lane codes are.
- R8: Masked operations use 32-bit elements when `size[0]`=0 and 64-bit elements when `size[0]`=1. An element is selected when the most significant bit of the matching element of `src_b` is 1.
- R9: Masked load (opcode 4) returns the selected elements of `src_a` unchanged and zero in every unselected element.
- R10: Masked store (opcode 5) returns `src_a` unchanged as write data. It sets `byte_en` bit k (byte k = bits [8k+7:8k]) to 1 for every byte of a selected element and to 0 for every byte of an unselected element.
- R11: For every opcode other than 5, `byte_en` is zero. Opcodes 6 and 7 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 3 | Operation select (0 broadcast, 1 insert, 2 extract, 3 permute, 4 masked load, 5 masked store) |
| size | input | 2 | Broadcast width, or element width in bit 0 for masked operations |
| imm | input | 8 | Immediate: half select for insert/extract, lane selector for permute |
| src_a | input | 256 | First source vector / masked data |
| src_b | input | 256 | Second source vector / element mask |
| scalar | input | 128 | Scalar operand for broadcast and insert |
| out_valid | output | 1 | Result present |
| result | output | 256 | Registered result vector |
| byte_en | output | 32 | Per-byte write enable for masked stores |

## Verification
The bench instantiates the block with its default lane width of 128 bits, which gives the full 256-bit vector, eight 32-bit words and 32 byte enables. At this width every lane code in the permute selector can be exercised. All four combinations of the two zero-force bits can be applied, and mask patterns can be chosen so that the element MSB of a 32-bit word and that of a 64-bit pair disagree. This shows that the element-size flag really changes which bits the masking logic samples.

// File: rtl/lane_mover_pkg.sv
package lane_mover_pkg;

    typedef enum logic [2:0] {
        OP_BCAST   = 3'd0,
        OP_INSERT  = 3'd1,
        OP_EXTRACT = 3'd2,
        OP_PERM    = 3'd3,
        OP_MLOAD   = 3'd4,
        OP_MSTORE  = 3'd5
    } lm_op_e;

    localparam int unsigned WORD_W = 32;

endpackage

// File: rtl/lm_bcast.sv
module lm_bcast #(
    parameter int unsigned LANE_W = 128
) (
    input  logic [LANE_W-1:0]   scalar,
    input  logic [1:0]          size,
    output logic [2*LANE_W-1:0] vec
);
    import lane_mover_pkg::*;

    localparam int unsigned VEC_W     = 2 * LANE_W;
    localparam int unsigned NWORDS    = VEC_W / WORD_W;
    localparam int unsigned LANE_WRDS = LANE_W / WORD_W;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_comb begin
            unique case (size)
                2'd0:    vec[w*WORD_W +: WORD_W] = scalar[WORD_W-1:0];
                2'd1:    vec[w*WORD_W +: WORD_W] = scalar[(w % 2)*WORD_W +: WORD_W];
                default: vec[w*WORD_W +: WORD_W] = scalar[(w % LANE_WRDS)*WORD_W +: WORD_W];
            endcase
        end
    end

endmodule

// File: rtl/lm_lane_sel.sv
module lm_lane_sel #(
    parameter int unsigned LANE_W = 128
) (
    input  logic [2*LANE_W-1:0] src_a,
    input  logic [2*LANE_W-1:0] src_b,
    input  logic [1:0]          code,
    input  logic                force_zero,
    output logic [LANE_W-1:0]   lane
);
    always_comb begin
        if (force_zero) begin
            lane = '0;
        end else begin
            unique case (code)
                2'd0: lane = src_a[LANE_W-1:0];
                2'd1: lane = src_a[2*LANE_W-1:LANE_W];
                2'd2: lane = src_b[LANE_W-1:0];
                default: lane = src_b[2*LANE_W-1:LANE_W];
            endcase
        end
    end

endmodule

// File: rtl/lm_mask.sv
module lm_mask #(
    parameter int unsigned VEC_W = 256
) (
    input  logic [VEC_W-1:0]         data,
    input  logic [VEC_W/32-1:0]      word_msb,
    input  logic                     elem64,
    output logic [VEC_W-1:0]         merged,
    output logic [VEC_W/8-1:0]       sel_bytes
);
    import lane_mover_pkg::*;

    localparam int unsigned NWORDS = VEC_W / WORD_W;
    localparam int unsigned WBYTES = WORD_W / 8;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic sel;
        // a 64-bit element takes its flag from the upper word of the pair
        assign sel = elem64 ? word_msb[w | 1] : word_msb[w];
        assign merged[w*WORD_W +: WORD_W]    = sel ? data[w*WORD_W +: WORD_W] : '0;
        assign sel_bytes[w*WBYTES +: WBYTES] = {WBYTES{sel}};
    end

endmodule

// File: rtl/lane_mover.sv
module lane_mover #(
    parameter int unsigned LANE_W = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            opcode,
    input  logic [1:0]            size,
    input  logic [7:0]            imm,
    input  logic [2*LANE_W-1:0]   src_a,
    input  logic [2*LANE_W-1:0]   src_b,
    input  logic [LANE_W-1:0]     scalar,
    output logic                  out_valid,
    output logic [2*LANE_W-1:0]   result,
    output logic [2*LANE_W/8-1:0] byte_en
);
    import lane_mover_pkg::*;

    localparam int unsigned VEC_W  = 2 * LANE_W;
    localparam int unsigned NBYTES = VEC_W / 8;
    localparam int unsigned NWORDS = VEC_W / WORD_W;

    typedef struct packed {
        logic              valid;
        logic [VEC_W-1:0]  data;
        logic [NBYTES-1:0] be;
    } out_t;

    out_t st_d, st_q;

    logic [VEC_W-1:0]  bcast_vec;
    logic [LANE_W-1:0] perm_lo, perm_hi;
    logic [VEC_W-1:0]  mask_merged;
    logic [NBYTES-1:0] mask_bytes;
    logic [NWORDS-1:0] word_msb;

    lm_bcast #(.LANE_W(LANE_W)) u_bcast (
        .scalar (scalar),
        .size   (size),
        .vec    (bcast_vec)
    );

    lm_lane_sel #(.LANE_W(LANE_W)) u_sel_lo (
        .src_a      (src_a),
        .src_b      (src_b),
        .code       (imm[1:0]),
        .force_zero (imm[3]),
        .lane       (perm_lo)
    );

    lm_lane_sel #(.LANE_W(LANE_W)) u_sel_hi (
        .src_a      (src_a),
        .src_b      (src_b),
        .code       (imm[5:4]),
        .force_zero (imm[7]),
        .lane       (perm_hi)
    );

    for (genvar w = 0; w < NWORDS; w++) begin : g_msb
        assign word_msb[w] = src_b[w*WORD_W + WORD_W - 1];
    end

    lm_mask #(.VEC_W(VEC_W)) u_mask (
        .data      (src_a),
        .word_msb  (word_msb),
        .elem64    (size[0]),
        .merged    (mask_merged),
        .sel_bytes (mask_bytes)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.be = '0;
            unique case (opcode)
                OP_BCAST:   st_d.data = bcast_vec;
                OP_INSERT:  st_d.data = imm[0] ? {scalar, src_a[LANE_W-1:0]}
                                               : {src_a[VEC_W-1:LANE_W], scalar};
                OP_EXTRACT: st_d.data = {{LANE_W{1'b0}},
                                         imm[0] ? src_a[VEC_W-1:LANE_W] : src_a[LANE_W-1:0]};
                OP_PERM:    st_d.data = {perm_hi, perm_lo};
                OP_MLOAD:   st_d.data = mask_merged;
                OP_MSTORE: begin
                    st_d.data = src_a;
                    st_d.be   = mask_bytes;
                end
                default:    st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.data;
    assign byte_en   = st_q.be;

endmodule

// File: rtl/lane_mover_chk.sv
module lane_mover_chk #(
    parameter int unsigned LANE_W = 128
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [2:0]            opcode,
    input logic [7:0]            imm,
    input logic [2*LANE_W-1:0]   src_a,
    input logic [2*LANE_W-1:0]   src_b,
    input logic                  out_valid,
    input logic [2*LANE_W-1:0]   result,
    input logic [2*LANE_W/8-1:0] byte_en
);
    localparam int unsigned VEC_W = 2 * LANE_W;

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(byte_en)));

    // R4
    insert_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd1 && !imm[0])
        |=> result[VEC_W-1:LANE_W] == $past(src_a[VEC_W-1:LANE_W]));

    // R5
    extract_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd2) |=> result[VEC_W-1:LANE_W] == '0);

    // R7
    perm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd3 && imm[3] && imm[7]) |=> result == '0);

    // R9
    mload_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd4 && src_b == '0) |=> result == '0);

    // R10
    mstore_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd5) |=> (result == $past(src_a)
                                          && ($countones(byte_en) % 4) == 0));

    // R11
    be_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode != 3'd5) |=> byte_en == '0);

endmodule

bind lane_mover lane_mover_chk #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .imm       (imm),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result),
    .byte_en   (byte_en)
);

// File: tb/lane_mover_bench.sv
`timescale 1ns/1ps
module lane_mover_bench;

    localparam int LW = 128;
    localparam int VW = 256;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [2:0]     opcode = '0;
    logic [1:0]     size = '0;
    logic [7:0]     imm = '0;
    logic [VW-1:0]  src_a = '0;
    logic [VW-1:0]  src_b = '0;
    logic [LW-1:0]  scalar = '0;
    logic           out_valid;
    logic [VW-1:0]  result;
    logic [31:0]    byte_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lane_mover #(.LANE_W(LW)) u_lane_mover (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .size(size), .imm(imm), .src_a(src_a), .src_b(src_b), .scalar(scalar),
        .out_valid(out_valid), .result(result), .byte_en(byte_en)
    );

    localparam logic [VW-1:0] VA = {32'hA7A7_0007, 32'hA6A6_0006, 32'hA5A5_0005, 32'hA4A4_0004,
                                    32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000};
    localparam logic [VW-1:0] VB = {32'hB7B7_0017, 32'hB6B6_0016, 32'hB5B5_0015, 32'hB4B4_0014,
                                    32'hB3B3_0013, 32'hB2B2_0012, 32'hB1B1_0011, 32'hB0B0_0010};
    localparam logic [LW-1:0] SC = 128'hC3C3_3333_C2C2_2222_C1C1_1111_C0C0_0000;

    task automatic check_vec(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [1:0] sz, input logic [7:0] im,
                         input logic [VW-1:0] a, input logic [VW-1:0] b);
        @(negedge clk);
        opcode = op; size = sz; imm = im; src_a = a; src_b = b; scalar = SC;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec("R2 out_valid", {255'b0, out_valid}, 256'd1);
    endtask

    function automatic logic [VW-1:0] mask_sel(input logic [VW-1:0] b, input bit e64);
        logic [VW-1:0] m = '0;
        for (int w = 0; w < 8; w++) begin
            bit s = e64 ? b[(w | 1)*32 + 31] : b[w*32 + 31];
            m[w*32 +: 32] = {32{s}};
        end
        return m;
    endfunction

    function automatic logic [31:0] mask_be(input logic [VW-1:0] b, input bit e64);
        logic [31:0] e = '0;
        for (int w = 0; w < 8; w++) begin
            bit s = e64 ? b[(w | 1)*32 + 31] : b[w*32 + 31];
            e[w*4 +: 4] = {4{s}};
        end
        return e;
    endfunction

    task automatic t_reset();
        check_vec("R1 out_valid", {255'b0, out_valid}, '0);
        check_vec("R1 result", result, '0);
        check_vec("R1 byte_en", {224'b0, byte_en}, '0);
    endtask

    task automatic t_bcast();
        apply(3'd0, 2'd0, 8'h00, VA, VB);
        check_vec("R3 size32", result, {8{SC[31:0]}});
        check_vec("R11 bcast be", {224'b0, byte_en}, '0);
        apply(3'd0, 2'd1, 8'h00, VA, VB);
        check_vec("R3 size64", result, {4{SC[63:0]}});
        apply(3'd0, 2'd2, 8'h00, VA, VB);
        check_vec("R3 size128", result, {2{SC}});
        apply(3'd0, 2'd3, 8'h00, VA, VB);
        check_vec("R3 size3", result, {2{SC}});
    endtask

    task automatic t_insert();
        apply(3'd1, 2'd0, 8'h00, VA, VB);
        check_vec("R4 low", result, {VA[255:128], SC});
        apply(3'd1, 2'd0, 8'hFF, VA, VB);
        check_vec("R4 high", result, {SC, VA[127:0]});
    endtask

    task automatic t_extract();
        apply(3'd2, 2'd0, 8'h00, VA, VB);
        check_vec("R5 low", result, {128'b0, VA[127:0]});
        apply(3'd2, 2'd0, 8'h01, VA, VB);
        check_vec("R5 high", result, {128'b0, VA[255:128]});
    endtask

    task automatic t_perm();
        apply(3'd3, 2'd0, 8'h20, VA, VB);
        check_vec("R6 a0 b0", result, {VB[127:0], VA[127:0]});
        apply(3'd3, 2'd0, 8'h13, VA, VB);
        check_vec("R6 b1 a1", result, {VA[255:128], VB[255:128]});
        apply(3'd3, 2'd0, 8'h31, VA, VB);
        check_vec("R6 a1 b1", result, {VB[255:128], VA[255:128]});
        apply(3'd3, 2'd0, 8'h08, VA, VB);
        check_vec("R7 low zero", result, {VA[127:0], 128'b0});
        apply(3'd3, 2'd0, 8'hB2, VA, VB);
        check_vec("R7 high zero", result, {128'b0, VB[127:0]});
        apply(3'd3, 2'd0, 8'h88, VA, VB);
        check_vec("R7 both zero", result, '0);
    endtask

    task automatic t_masked();
        // word MSBs differ inside pairs so 32 and 64 bit element views disagree
        logic [VW-1:0] mb;
        mb = {32'h8000_0000, 32'h0, 32'h0, 32'h8000_0000,
              32'h0, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFF};
        apply(3'd4, 2'd0, 8'h00, VA, mb);
        check_vec("R9 R8 load32", result, VA & mask_sel(mb, 1'b0));
        check_vec("R11 load be", {224'b0, byte_en}, '0);
        apply(3'd4, 2'd1, 8'h00, VA, mb);
        check_vec("R9 R8 load64", result, VA & mask_sel(mb, 1'b1));
        apply(3'd5, 2'd0, 8'h00, VA, mb);
        check_vec("R10 store32 data", result, VA);
        check_vec("R10 store32 be", {224'b0, byte_en}, {224'b0, mask_be(mb, 1'b0)});
        apply(3'd5, 2'd1, 8'h00, VA, mb);
        check_vec("R10 R8 store64 be", {224'b0, byte_en}, {224'b0, mask_be(mb, 1'b1)});
        apply(3'd5, 2'd0, 8'h00, VA, '0);
        check_vec("R10 store none", {224'b0, byte_en}, '0);
    endtask

    task automatic t_other();
        apply(3'd6, 2'd0, 8'hFF, VA, VB);
        check_vec("R11 op6", result, '0);
        apply(3'd7, 2'd2, 8'h00, VA, VB);
        check_vec("R11 op7 be", {224'b0, byte_en}, '0);
    endtask

    task automatic t_hold();
        logic [VW-1:0] last;
        apply(3'd5, 2'd0, 8'h00, VA, {8{32'h8000_0000}});
        last = result;
        @(negedge clk);
        check_vec("R2 idle valid", {255'b0, out_valid}, '0);
        check_vec("R2 idle result", result, last);
        check_vec("R2 idle be", {224'b0, byte_en}, {224'b0, 32'hFFFF_FFFF});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bcast();
        t_insert();
        t_extract();
        t_perm();
        t_masked();
        t_other();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule